// File: doc/BRIEF.md
# Byte Lane Serializer

The block turns a stream of 32-bit words into a stream of bytes on an 8-bit parallel bus. Each output channel has its own small word FIFO, an output shift register (OSR) and a sequencer. A DMA engine keeps the FIFO topped up. It writes a word whenever the channel's request line is high, and the request stays high as long as the FIFO has a free slot. A divider elsewhere supplies a one-cycle enable pulse (a tick) at the sample rate. Each tick puts the next byte on the channel's lane. The order is the least significant byte first, then the higher bytes in turn.

Every word gives four samples. The sample rate is therefore the waveform frequency times four times the number of words in one period. The sequencer has three states:
- `ST_EMPTY`: nothing has been loaded yet since reset.
- `ST_LOADED`: the OSR holds a word, and a byte index selects the next byte.
- `ST_STARVED`: the last word is used up and no new word arrived in time.

The state changes are:
- `EMPTY→LOADED` and `STARVED→LOADED` are refills. They take the head word from the FIFO without waiting for a tick.
- `LOADED→LOADED` on the fourth tick of a word is the seamless reload. The next word is taken on that same tick, so the following tick already has a byte ready.
- `LOADED→STARVED` happens on the fourth tick when the FIFO is empty.

A tick in `ST_STARVED` keeps the lane at its last byte and sets a sticky underrun flag. Several channels are built side by side and share nothing but the clock and reset.

Top module: `byte_lane_serializer`

## Requirements
- R1: After reset every lane reads 0x00, every underrun flag is 0 and every request line is 1.
- R2: A channel's request line is 1 while its FIFO holds fewer than 4 words and 0 when it holds 4. A word already moved into the OSR does not count.
- R3: A write presented while the channel's request line is 0 is discarded and never appears on the lane.
- R4: A tick in a loaded channel puts the next byte on the lane in the cycle after the tick. The bytes of a word come in the order bits 7:0, 15:8, 23:16, 31:24.
- R5: In a cycle without a tick the lane keeps its value.
- R6: Ticks on consecutive cycles across word boundaries produce every byte exactly once, with no repeated or skipped byte, as long as the FIFO holds the next word.
- R7: A word written while the OSR is empty is moved into it without a tick. A tick two cycles after the write emits that word's bits 7:0.
- R8: A tick when the OSR is used up and the FIFO is empty leaves the lane at its last byte and sets the channel's underrun flag. The flag stays 1 until reset.
- R9: Ticks before any word has been written leave the lane at 0x00 and do not set the underrun flag.
- R10: Writes, ticks and state in one channel have no effect on any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | NUM_CH | Per-channel word write strobe from the DMA |
| wr_data | input | NUM_CH*WORD_W | Per-channel write word; channel c uses bits c*32 +: 32 |
| tick | input | NUM_CH | Per-channel sample enable pulse from the divider |
| dreq | output | NUM_CH | Per-channel request: FIFO has room |
| lane_out | output | NUM_CH*LANE_W | Per-channel byte lane; channel c uses bits c*8 +: 8 |
| underrun | output | NUM_CH | Per-channel sticky underrun flag |

## Verification
The assertions check the following on every cycle:
- The lane never moves without a tick.
- The underrun flag never clears once set, and it can only rise on a tick.
- The request line can only drop after a write.
- A channel that has never received a write stays quiet.

The byte order, the seamless reload across word boundaries, the dropping of writes into a full FIFO and the recovery after starvation need a reference byte stream. Only the bench scenarios can show them, by comparing the lane against a queue of the accepted words.

// File: rtl/blsr_pkg.sv
package blsr_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_LOADED  = 2'd1,
        ST_STARVED = 2'd2
    } osr_state_e;

endpackage

// File: rtl/blsr_word_fifo.sv
module blsr_word_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic              push;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign push  = push_req && !full;
    assign head  = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= bump(wptr);
            end
            if (pop) begin
                rptr <= bump(rptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/blsr_unpacker.sv
module blsr_unpacker
    import blsr_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_head,
    output logic              fifo_pop,
    output logic [LANE_W-1:0] lane,
    output logic              underrun
);
    localparam int LANES = WORD_W / LANE_W;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    osr_state_e        state, state_nxt;
    logic [WORD_W-1:0] osr;
    logic [IDX_W-1:0]  idx;
    logic              emit, starve_hit, last_lane;

    assign last_lane = (idx == IDX_W'(LANES - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions and control outputs
    always_comb begin
        state_nxt  = state;
        fifo_pop   = 1'b0;
        emit       = 1'b0;
        starve_hit = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (!fifo_empty) begin
                    fifo_pop  = 1'b1;
                    state_nxt = ST_LOADED;
                end
            end
            ST_LOADED: begin
                if (tick) begin
                    emit = 1'b1;
                    if (last_lane) begin
                        if (!fifo_empty) begin
                            fifo_pop = 1'b1;
                        end else begin
                            state_nxt = ST_STARVED;
                        end
                    end
                end
            end
            ST_STARVED: begin
                starve_hit = tick;
                if (!fifo_empty) begin
                    fifo_pop  = 1'b1;
                    state_nxt = ST_LOADED;
                end
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // Shift register, byte index, lane and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osr      <= '0;
            idx      <= '0;
            lane     <= '0;
            underrun <= 1'b0;
        end else begin
            if (emit) begin
                lane <= osr[int'(idx)*LANE_W +: LANE_W];
            end
            if (fifo_pop) begin
                osr <= fifo_head;
                idx <= '0;
            end else if (emit) begin
                idx <= idx + 1'b1;
            end
            if (starve_hit) begin
                underrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/byte_lane_serializer.sv
module byte_lane_serializer #(
    parameter int NUM_CH     = 2,
    parameter int WORD_W     = 32,
    parameter int LANE_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        wr_valid,
    input  logic [NUM_CH*WORD_W-1:0] wr_data,
    input  logic [NUM_CH-1:0]        tick,
    output logic [NUM_CH-1:0]        dreq,
    output logic [NUM_CH*LANE_W-1:0] lane_out,
    output logic [NUM_CH-1:0]        underrun
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic              full, empty, pop;
        logic [WORD_W-1:0] head;

        blsr_word_fifo #(
            .WORD_W (WORD_W),
            .DEPTH  (FIFO_DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_req  (wr_valid[c]),
            .push_data (wr_data[c*WORD_W +: WORD_W]),
            .pop       (pop),
            .head      (head),
            .full      (full),
            .empty     (empty)
        );

        blsr_unpacker #(
            .WORD_W (WORD_W),
            .LANE_W (LANE_W)
        ) u_unpack (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick[c]),
            .fifo_empty (empty),
            .fifo_head  (head),
            .fifo_pop   (pop),
            .lane       (lane_out[c*LANE_W +: LANE_W]),
            .underrun   (underrun[c])
        );

        assign dreq[c] = !full;
    end

endmodule

// File: rtl/byte_lane_serializer_chk.sv
module byte_lane_serializer_chk #(
    parameter int NUM_CH = 2,
    parameter int LANE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        wr_valid,
    input logic [NUM_CH-1:0]        tick,
    input logic [NUM_CH-1:0]        dreq,
    input logic [NUM_CH*LANE_W-1:0] lane_out,
    input logic [NUM_CH-1:0]        underrun
);
    logic [NUM_CH-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else begin
            seen <= seen | wr_valid;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            !tick[c] |=> $stable(lane_out[c*LANE_W +: LANE_W])); // R5
        AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            underrun[c] |=> underrun[c]); // R8
        AST_UNDERRUN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(underrun[c]) |-> $past(tick[c])); // R8
        AST_DREQ_DROP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(dreq[c]) |-> $past(wr_valid[c])); // R2
        AST_QUIET_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            !seen[c] |-> (lane_out[c*LANE_W +: LANE_W] == '0 && !underrun[c])); // R9
    end

endmodule

bind byte_lane_serializer byte_lane_serializer_chk #(
    .NUM_CH (NUM_CH),
    .LANE_W (LANE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .tick     (tick),
    .dreq     (dreq),
    .lane_out (lane_out),
    .underrun (underrun)
);

// File: tb/byte_lane_serializer_tb.sv
module byte_lane_serializer_tb;
    localparam int NCH = 2;
    localparam int WW  = 32;
    localparam int LW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    wr_valid = '0;
    logic [NCH*WW-1:0] wr_data = '0;
    logic [NCH-1:0]    tick = '0;
    logic [NCH-1:0]    dreq;
    logic [NCH*LW-1:0] lane_out;
    logic [NCH-1:0]    underrun;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [LW-1:0] mq [NCH][$];
    logic [LW-1:0] exp_lane [NCH];
    logic          exp_und [NCH];
    bit            started [NCH];

    byte_lane_serializer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .tick     (tick),
        .dreq     (dreq),
        .lane_out (lane_out),
        .underrun (underrun)
    );

    always #5 clk = ~clk;

    function automatic logic [WW-1:0] pattern(input int i);
        return 32'h13121110 + WW'(i) * 32'h04040404;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            mq[c].delete();
            exp_lane[c] = '0;
            exp_und[c]  = 1'b0;
            started[c]  = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        wr_valid = '0;
        tick     = '0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a falling edge: drive one cycle of stimulus, then check.
    task automatic cycle(input logic [NCH-1:0] wm, input logic [NCH*WW-1:0] wd,
                         input logic [NCH-1:0] tm, input string tick_req);
        for (int c = 0; c < NCH; c++) begin
            if (wm[c] && dreq[c]) begin
                for (int b = 0; b < WW / LW; b++) begin
                    mq[c].push_back(wd[c*WW + b*LW +: LW]);
                end
            end
        end
        wr_valid = wm;
        wr_data  = wd;
        tick     = tm;
        @(negedge clk);
        wr_valid = '0;
        tick     = '0;
        for (int c = 0; c < NCH; c++) begin
            if (tm[c]) begin
                if (mq[c].size() > 0) begin
                    exp_lane[c] = mq[c].pop_front();
                    started[c]  = 1'b1;
                end else if (started[c]) begin
                    exp_und[c] = 1'b1;
                end
            end
            check(tm[c] ? tick_req : "R5", 32'(lane_out[c*LW +: LW]),
                  32'(exp_lane[c]), $sformatf("ch%0d lane", c));
            check("R8", 32'(underrun[c]), 32'(exp_und[c]),
                  $sformatf("ch%0d underrun", c));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle('0, '0, '0, "R5");
    endtask

    initial begin
        int since [NCH];
        void'($urandom(32'h00C0FFEE));
        model_reset();
        do_reset();

        // R1: reset state
        check("R1", 32'(lane_out), 32'h0, "lanes");
        check("R1", 32'(underrun), 32'h0, "underrun");
        check("R1", 32'(dreq), 32'h3, "dreq");

        // R9: ticks with no data on ch1
        for (int i = 0; i < 3; i++) cycle('0, '0, 2'b10, "R9");
        check("R9", 32'(underrun[1]), 32'h0, "ch1 underrun before data");

        // R2: fill ch0 (first word lands in the OSR, four more fill the FIFO)
        for (int i = 0; i < 5; i++) cycle(2'b01, {32'h0, pattern(i)}, '0, "R4");
        check("R2", 32'(dreq[0]), 32'h0, "ch0 dreq with full FIFO");
        check("R10", 32'(dreq[1]), 32'h1, "ch1 dreq unaffected");

        // R3: write into a full FIFO is dropped
        cycle(2'b01, {32'h0, 32'hDEADBEEF}, '0, "R3");
        idle(2);

        // R4: first word, LSB first
        for (int i = 0; i < 4; i++) cycle('0, '0, 2'b01, "R4");
        check("R2", 32'(dreq[0]), 32'h1, "ch0 dreq after reload frees a slot");

        // R6: back-to-back ticks across four word boundaries
        for (int i = 0; i < 16; i++) cycle('0, '0, 2'b01, "R6");

        // R3/R8: stream ends with the last accepted word, lane holds, flag sets
        cycle('0, '0, 2'b01, "R3");
        check("R3", 32'(lane_out[7:0]), 32'(pattern(4) >> 24), "ch0 held last byte");
        check("R8", 32'(underrun[0]), 32'h1, "ch0 underrun set");
        cycle('0, '0, 2'b01, "R8");

        // R7: recovery; R10: ch1 runs while ch0 is starved
        cycle(2'b11, {32'hA5A4A3A2, pattern(6)}, '0, "R7");
        idle(1);
        cycle('0, '0, 2'b11, "R7");
        check("R7", 32'(lane_out[7:0]), 32'(pattern(6) & 32'hFF), "ch0 byte0 after refill");
        check("R10", 32'(lane_out[15:8]), 32'hA2, "ch1 first byte");
        check("R10", 32'(underrun[1]), 32'h0, "ch1 flag independent");
        check("R8", 32'(underrun[0]), 32'h1, "ch0 flag still set");

        // Random phase
        do_reset();
        for (int c = 0; c < NCH; c++) since[c] = 2;
        for (int n = 0; n < 4000; n++) begin
            logic [NCH-1:0]    wm = '0;
            logic [NCH-1:0]    tm = '0;
            logic [NCH*WW-1:0] wd = '0;
            for (int c = 0; c < NCH; c++) begin
                int r = int'($urandom % 10);
                if (since[c] < 100) since[c]++;
                if (r < 3) begin
                    wm[c] = 1'b1;
                    wd[c*WW +: WW] = $urandom;
                    since[c] = 0;
                end else if (r < 8 && since[c] >= 2) begin
                    tm[c] = 1'b1;
                end
            end
            cycle(wm, wd, tm, "R4");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule